// File: doc/BRIEF.md
# Warp-Level Execution Cycle Estimator

This block gives a coarse estimate of how many core cycles a parallel kernel needs when it runs on a chosen number of active clusters. It takes a set of kernel figures: compute cycles per period, global and cache latencies, a cache miss fraction, bytes loaded per thread, memory bandwidth per core cycle, total workload and total warp count. From these it derives the average memory period, the bytes each warp fetches and the memory-warp parallelism. It then picks a compute-bound or a memory-bound formula. A runtime governor issues one request per candidate cluster count, compares the returned estimates, and keeps the fewest clusters that do not lose performance.

All arithmetic is unsigned fixed point. One shared 32-step restoring divider performs five divisions in turn, so each request takes a fixed number of cycles. The kernel figures are captured when a request is accepted.

Top module: `est_cycle_estimator`

## Requirements
- R1: While rst_ni is low, and after it is released until the first result, valid_o is 0 and est_o is 0.
- R2: The memory period is mem = floor((glob·m + cache·(65536−m)) / 65536), where m is miss_rate_i as an unsigned Q0.16 fraction. The bytes per warp are lbw = floor(ld_bytes·32·m / 65536).
- R3: Every division is an unsigned floor division. A zero divisor yields 0xFFFFFFFF. repeat = floor(workload/warps) and per_cluster = floor(warps/clusters).
- R4: The ratio is floor(mem·256/comp) and MWP is floor(bw·mem·256/(clusters·lbw)). Both are Q24.8. An MWP of 0 is raised to 1 (1/256).
- R5: If MWP ≥ ratio, the estimate is mem + repeat·per_cluster·comp.
- R6: Otherwise the estimate is repeat·per_cluster·floor(mem·256/MWP).
- R7: An estimate above 2^32−1 is returned as 0xFFFFFFFF.
- R8: valid_o is high for exactly one cycle, 165 clock edges after the edge that accepted the request. est_o changes only on that edge and holds otherwise.
- R9: A request is ignored if it arrives while a computation is in progress (including the edge that raises valid_o) or if clusters_i is 0.
- R10: The kernel figures and cluster count are sampled at the accepting edge. Changes to them during the computation do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe |
| clusters_i | input | 8 | Active cluster count |
| comp_cyc_i | input | 16 | Compute cycles per period |
| glob_lat_i | input | 16 | Global memory latency |
| cache_lat_i | input | 16 | Cache latency |
| miss_rate_i | input | 16 | Miss fraction, Q0.16 |
| ld_bytes_i | input | 16 | Bytes loaded per thread per memory period |
| bw_i | input | 8 | Memory bytes per core cycle |
| workload_i | input | 32 | Total workload |
| warps_i | input | 32 | Total warps |
| valid_o | output | 1 | Result strobe |
| est_o | output | 32 | Estimated total cycles |

## Verification
The hardest states to reach are the divider's zero and saturated outcomes: the MWP floor of 1/256, a zero byte count that drives MWP to all ones, and a product that overflows 32 bits. The stimulus reaches them directly. Zero bandwidth forces the floor. Zero miss rate removes all global traffic. A large workload on a single cluster overflows the product. A second request with new figures is injected mid-computation, and a request is held high across two windows, to exercise the acceptance rule at the exact edge where valid_o rises.

// File: rtl/est_pkg.sv
package est_pkg;
  localparam int LAT_W    = 16;
  localparam int BW_W     = 8;
  localparam int K_W      = 8;
  localparam int CNT_W    = 32;
  localparam int DIV_W    = 32;
  localparam int QF_W     = 8;
  localparam int LANES_LG = 5;
  localparam int LBW_W    = LAT_W + LANES_LG;
  localparam int N_OPS    = 5;
  localparam int IDX_W    = $clog2(N_OPS);
  localparam int LATENCY  = N_OPS * (DIV_W + 1);

  function automatic logic [CNT_W-1:0] sat_cnt(input logic [2*CNT_W-1:0] v);
    return (v[2*CNT_W-1:CNT_W] != '0) ? '1 : v[CNT_W-1:0];
  endfunction
endpackage

// File: rtl/est_memparm.sv
module est_memparm import est_pkg::*; (
  input  logic [LAT_W-1:0] glob_lat_i,
  input  logic [LAT_W-1:0] cache_lat_i,
  input  logic [LAT_W-1:0] miss_i,
  input  logic [LAT_W-1:0] ld_bytes_i,
  output logic [LAT_W-1:0] mem_cyc_o,
  output logic [LBW_W-1:0] lbw_o
);
  localparam int ACC_W = 2 * LAT_W + 2;
  localparam int PB_W  = LBW_W + LAT_W;

  logic [ACC_W-1:0] acc;
  logic [PB_W-1:0]  pb;

  always_comb begin
    acc = ACC_W'(glob_lat_i) * ACC_W'(miss_i)
        + ACC_W'(cache_lat_i) * (ACC_W'(1) << LAT_W) - ACC_W'(cache_lat_i) * ACC_W'(miss_i);
    pb  = PB_W'({ld_bytes_i, {LANES_LG{1'b0}}}) * PB_W'(miss_i);
    mem_cyc_o = LAT_W'(acc >> LAT_W);
    lbw_o     = LBW_W'(pb >> LAT_W);
  end
endmodule

// File: rtl/est_div.sv
module est_div #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         done_o,
  output logic [W-1:0] quot_o
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  q_q, d_q, r_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;
  logic [W:0]    trial;
  logic          fit;

  always_comb begin
    trial = {r_q, q_q[W-1]};
    fit   = trial >= {1'b0, d_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q <= '0; d_q <= '0; r_q <= '0; cnt_q <= '0; done_q <= 1'b0;
    end else if (load_i) begin
      q_q    <= dividend_i;
      d_q    <= divisor_i;
      r_q    <= '0;
      cnt_q  <= CW'(W);
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (cnt_q != '0) begin
        r_q   <= fit ? (trial[W-1:0] - d_q) : trial[W-1:0];
        q_q   <= {q_q[W-2:0], fit};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) done_q <= 1'b1;
      end
    end
  end

  assign done_o = done_q;
  assign quot_o = q_q;
endmodule

// File: rtl/est_combine.sv
module est_combine import est_pkg::*; (
  input  logic [CNT_W-1:0] rep_i,
  input  logic [CNT_W-1:0] wpc_i,
  input  logic [LAT_W-1:0] mem_i,
  input  logic [LAT_W-1:0] comp_i,
  input  logic [CNT_W-1:0] tmem_i,
  input  logic [CNT_W-1:0] mwp_i,
  input  logic [CNT_W-1:0] ratio_i,
  output logic [CNT_W-1:0] est_o
);
  logic [CNT_W-1:0] s1, s_cmp, s_mem;
  logic [CNT_W:0]   sum;

  always_comb begin
    s1    = sat_cnt((2*CNT_W)'(rep_i) * (2*CNT_W)'(wpc_i));
    s_cmp = sat_cnt((2*CNT_W)'(s1) * (2*CNT_W)'(comp_i));
    s_mem = sat_cnt((2*CNT_W)'(s1) * (2*CNT_W)'(tmem_i));
    sum   = (CNT_W+1)'(s_cmp) + (CNT_W+1)'(mem_i);
    if (mwp_i >= ratio_i) est_o = sum[CNT_W] ? '1 : sum[CNT_W-1:0];
    else                  est_o = s_mem;
  end
endmodule

// File: rtl/est_cycle_estimator.sv
module est_cycle_estimator import est_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [K_W-1:0]    clusters_i,
  input  logic [LAT_W-1:0]  comp_cyc_i,
  input  logic [LAT_W-1:0]  glob_lat_i,
  input  logic [LAT_W-1:0]  cache_lat_i,
  input  logic [LAT_W-1:0]  miss_rate_i,
  input  logic [LAT_W-1:0]  ld_bytes_i,
  input  logic [BW_W-1:0]   bw_i,
  input  logic [CNT_W-1:0]  workload_i,
  input  logic [CNT_W-1:0]  warps_i,
  output logic              valid_o,
  output logic [CNT_W-1:0]  est_o
);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(N_OPS - 1);
  localparam int BM_W = BW_W + LAT_W;

  logic             busy_q;
  logic [IDX_W-1:0] idx_q, op_sel;
  logic [K_W-1:0]   k_q;
  logic [LAT_W-1:0] comp_q, glob_q, cache_q, miss_q, ldb_q;
  logic [BW_W-1:0]  bw_q;
  logic [CNT_W-1:0] warps_q, rep_q, wpc_q, ratio_q, mwp_q;
  logic [LAT_W-1:0] mem_cyc;
  logic [LBW_W-1:0] lbw;
  logic [BM_W-1:0]  bwm;
  logic             accept, div_load, div_done;
  logic [DIV_W-1:0] div_dvd, div_dvs, div_q, mwp_clamp;
  logic [CNT_W-1:0] est_next;

  est_memparm u_memparm (
    .glob_lat_i(glob_q), .cache_lat_i(cache_q), .miss_i(miss_q),
    .ld_bytes_i(ldb_q), .mem_cyc_o(mem_cyc), .lbw_o(lbw)
  );

  assign accept    = !busy_q && req_i && (clusters_i != '0);
  assign div_load  = accept || (div_done && idx_q != IDX_LAST);
  assign op_sel    = accept ? '0 : idx_q + 1'b1;
  assign mwp_clamp = (div_q == '0) ? DIV_W'(1) : div_q;
  assign bwm       = BM_W'(bw_q) * BM_W'(mem_cyc);

  // operands for the division issued at this edge
  always_comb begin
    div_dvd = '0;
    div_dvs = '0;
    case (op_sel)
      IDX_W'(0): begin div_dvd = workload_i; div_dvs = warps_i; end
      IDX_W'(1): begin div_dvd = warps_q; div_dvs = DIV_W'(k_q); end
      IDX_W'(2): begin div_dvd = DIV_W'({mem_cyc, {QF_W{1'b0}}}); div_dvs = DIV_W'(comp_q); end
      IDX_W'(3): begin div_dvd = DIV_W'({bwm, {QF_W{1'b0}}}); div_dvs = DIV_W'(k_q) * DIV_W'(lbw); end
      default:   begin div_dvd = DIV_W'({mem_cyc, {QF_W{1'b0}}}); div_dvs = mwp_clamp; end
    endcase
  end

  est_div #(.W(DIV_W)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(div_load),
    .dividend_i(div_dvd), .divisor_i(div_dvs), .done_o(div_done), .quot_o(div_q)
  );

  est_combine u_combine (
    .rep_i(rep_q), .wpc_i(wpc_q), .mem_i(mem_cyc), .comp_i(comp_q),
    .tmem_i(div_q), .mwp_i(mwp_q), .ratio_i(ratio_q), .est_o(est_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; idx_q <= '0; valid_o <= 1'b0; est_o <= '0;
      k_q <= '0; comp_q <= '0; glob_q <= '0; cache_q <= '0; miss_q <= '0;
      ldb_q <= '0; bw_q <= '0; warps_q <= '0;
      rep_q <= '0; wpc_q <= '0; ratio_q <= '0; mwp_q <= '0;
    end else begin
      valid_o <= 1'b0;
      if (accept) begin
        busy_q  <= 1'b1;
        idx_q   <= '0;
        k_q     <= clusters_i;
        comp_q  <= comp_cyc_i;
        glob_q  <= glob_lat_i;
        cache_q <= cache_lat_i;
        miss_q  <= miss_rate_i;
        ldb_q   <= ld_bytes_i;
        bw_q    <= bw_i;
        warps_q <= warps_i;
      end else if (busy_q && div_done) begin
        case (idx_q)
          IDX_W'(0): rep_q   <= div_q;
          IDX_W'(1): wpc_q   <= div_q;
          IDX_W'(2): ratio_q <= div_q;
          IDX_W'(3): mwp_q   <= mwp_clamp;
          default: ;
        endcase
        if (idx_q == IDX_LAST) begin
          busy_q  <= 1'b0;
          valid_o <= 1'b1;
          est_o   <= est_next;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/est_cycle_estimator_chk.sv
module est_cycle_estimator_chk import est_pkg::*; (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic [K_W-1:0]   clusters_i,
  input logic             valid_o,
  input logic [CNT_W-1:0] est_o,
  input logic             busy_q,
  input logic             div_load,
  input logic             div_done,
  input logic [DIV_W-1:0] div_dvd,
  input logic [DIV_W-1:0] div_dvs,
  input logic [DIV_W-1:0] div_q
);
  logic [DIV_W-1:0] dvd_c, dvs_c;
  logic [9:0]       since_q;
  logic [2*DIV_W-1:0] prod;

  assign prod = (2*DIV_W)'(div_q) * (2*DIV_W)'(dvs_c);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dvd_c <= '0; dvs_c <= '0; since_q <= '0;
    end else begin
      if (div_load) begin dvd_c <= div_dvd; dvs_c <= div_dvs; end
      if (!busy_q && req_i && clusters_i != '0) since_q <= 10'd1;
      else if (since_q != '0 && since_q != '1) since_q <= since_q + 1'b1;
    end
  end

  AST_DIV_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_done |-> ((dvs_c == '0) ? (div_q == '1)
                 : (prod <= (2*DIV_W)'(dvd_c) && (2*DIV_W)'(dvd_c) - prod < (2*DIV_W)'(dvs_c)))); // R3
  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> since_q == 10'(LATENCY + 1)); // R8
  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R8
  AST_EST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(est_o)); // R8
  AST_ZERO_CLUSTERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && req_i && clusters_i == '0) |=> !busy_q); // R9
endmodule

bind est_cycle_estimator est_cycle_estimator_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .clusters_i(clusters_i),
  .valid_o(valid_o), .est_o(est_o), .busy_q(busy_q), .div_load(div_load),
  .div_done(div_done), .div_dvd(div_dvd), .div_dvs(div_dvs), .div_q(div_q)
);

// File: tb/est_cycle_estimator_tb.sv
module est_cycle_estimator_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req;
  logic [7:0]  k;
  logic [15:0] comp, glob, cache, miss, ldb;
  logic [7:0]  bw;
  logic [31:0] work, warps;
  logic        valid;
  logic [31:0] est;

  always #10 clk = ~clk;

  est_cycle_estimator u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .clusters_i(k), .comp_cyc_i(comp),
    .glob_lat_i(glob), .cache_lat_i(cache), .miss_rate_i(miss), .ld_bytes_i(ldb),
    .bw_i(bw), .workload_i(work), .warps_i(warps), .valid_o(valid), .est_o(est)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0, mcnt = 0;
  string cur_req = "R1";
  logic        exp_valid = 1'b0;
  logic [31:0] exp_est = '0, pend = '0;

  function automatic logic [31:0] dv(logic [127:0] a, logic [127:0] b);
    if (b == 0) return 32'hFFFF_FFFF;
    return 32'(a / b);
  endfunction

  // behavioural reference of R2..R7
  function automatic logic [31:0] ref_est();
    logic [127:0] m, lb, rep, wpc, rat, mwp, tm, e;
    m   = (128'(glob) * miss + 128'(cache) * (65536 - 128'(miss))) >> 16;
    lb  = (128'(ldb) * 32 * miss) >> 16;
    rep = dv(work, warps);
    wpc = dv(warps, k);
    rat = dv(m * 256, comp);
    mwp = dv(128'(bw) * m * 256, 128'(k) * lb);
    if (mwp == 0) mwp = 1;
    tm  = dv(m * 256, mwp);
    if (mwp >= rat) e = m + rep * wpc * comp;
    else            e = rep * wpc * tm;
    return (e > 128'hFFFF_FFFF) ? 32'hFFFF_FFFF : e[31:0];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mcnt = 0; exp_valid = 1'b0; exp_est = '0;
    end else begin
      exp_valid = 1'b0;
      if (mcnt > 0) begin
        mcnt = mcnt - 1;
        if (mcnt == 0) begin exp_valid = 1'b1; exp_est = pend; end
      end else if (req && k != 0) begin
        pend = ref_est();
        mcnt = 165;
      end
    end
  end

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      chk("R1 valid", 32'(valid), 32'(1'b0));
      chk("R1 est", est, 32'h0);
    end else begin
      chk($sformatf("R8/%s valid", cur_req), 32'(valid), 32'(exp_valid));
      chk($sformatf("%s est", cur_req), est, exp_est);
    end
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic set_in(input logic [7:0] kk, input logic [15:0] cc, gg, ch, mr, lb,
                        input logic [7:0] b, input logic [31:0] wl, wp);
    k = kk; comp = cc; glob = gg; cache = ch; miss = mr; ldb = lb; bw = b; work = wl; warps = wp;
  endtask

  task automatic pulse();
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; req = 1'b0;
    set_in(0, 0, 0, 0, 0, 0, 0, 0, 0);
    idle(4);
    rst_n = 1'b1;
    idle(3);
    // R5: compute-bound
    cur_req = "R5";
    @(negedge clk); set_in(8, 20, 400, 20, 16'h4000, 4, 64, 32'd1_000_000, 32'd4096); pulse(); idle(170);
    // R6: memory-bound with full miss rate (R2 extremes)
    cur_req = "R6";
    @(negedge clk); set_in(16, 10, 600, 30, 16'hFFFF, 16, 32, 32'd500_000, 32'd2048); pulse(); idle(170);
    // R2: zero miss, memory period equals cache latency, no global bytes
    cur_req = "R2";
    @(negedge clk); set_in(4, 3, 900, 25, 16'h0000, 8, 16, 32'd80_000, 32'd1000); pulse(); idle(170);
    // R4: zero bandwidth drives MWP to its 1/256 floor
    cur_req = "R4";
    @(negedge clk); set_in(12, 7, 300, 40, 16'h8000, 8, 0, 32'd60_000, 32'd777); pulse(); idle(170);
    // R3: zero warps gives all-ones repeat and zero per-cluster
    cur_req = "R3";
    @(negedge clk); set_in(5, 9, 200, 10, 16'h2000, 2, 50, 32'd1234, 32'd0); pulse(); idle(170);
    // R7: overflow saturates
    cur_req = "R7";
    @(negedge clk); set_in(1, 100, 50, 50, 16'h0000, 4, 8, 32'h8000_0000, 32'h0010_0000); pulse(); idle(170);
    // R7: memory-bound overflow
    @(negedge clk); set_in(1, 1, 65535, 65535, 16'hFFFF, 65535, 0, 32'hFFFF_FFFF, 32'd1); pulse(); idle(170);
    // R9: zero clusters ignored
    cur_req = "R9";
    @(negedge clk); set_in(0, 20, 400, 20, 16'h4000, 4, 64, 32'd1000, 32'd100); pulse(); idle(170);
    // R10 / R9: new request and new figures mid-run are ignored
    cur_req = "R10";
    @(negedge clk); set_in(6, 15, 500, 35, 16'h3000, 12, 40, 32'd900_000, 32'd3000); pulse();
    idle(50);
    set_in(2, 1, 9, 9, 16'hF000, 1, 1, 32'd5, 32'd5); pulse();
    idle(130);
    // R8 / R9: request held high accepts again only after the result edge
    cur_req = "R8";
    @(negedge clk); set_in(3, 11, 700, 15, 16'h1234, 6, 90, 32'd300_000, 32'd999);
    req = 1'b1; idle(340); req = 1'b0; idle(180);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule